// File: doc/BRIEF.md
# Dual-Mode Programmable Down-Counting Timer

This block is a down-counting timer with a dedicated output pin. A control write with the run bit set loads the counter from a programmable reload value. The counter then decrements once per clock. When it is at zero, the next clock is an expiry: the counter reloads and keeps running. The time between expiries is therefore the reload value plus one clock.

Each expiry drives the output pin in one of two ways. In pulse mode the pin rests low and goes high for a single clock per expiry. In toggle mode the pin inverts at every expiry. A sticky expiry flag records that an expiry happened, and a one-cycle clear strobe resets it. Clearing the run bit freezes the counter and holds the pin low. The live count is brought out so that the state can be observed.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the output pin is low, the expiry flag is 0, the count is 0 and the timer is stopped.
- R2: A control write with run=1 loads the count from the reload value, in the clock edge of the write. From then on the count falls by one per clock. The clock after the count reads 0 is an expiry, which reloads the count. Expiries repeat every reload+1 clocks.
- R3: Pulse mode (toggle bit = 0): the output pin is high for exactly the one clock that follows each expiry, and low at every other time.
- R4: Toggle mode (toggle bit = 1): the output pin inverts at each expiry and holds its level between expiries.
- R5: With a reload value of 0 an expiry happens every clock. In pulse mode the pin stays high. In toggle mode it alternates every clock.
- R6: A control write with run=0 freezes the count at its current value, holds the output pin low and stops all expiries.
- R7: The expiry flag sets on every expiry and stays set until a clear strobe. An expiry in the same clock as a clear leaves the flag set.
- R8: Every control write restarts the count from the reload value and drives the output pin low, even while the timer is running.
- R9: A reload write during a run leaves the current count alone. The new value is first used at the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reloadWr | input | 1 | One-cycle strobe that writes the reload value |
| reloadData | input | 32 | Reload value to be written |
| ctrlWr | input | 1 | One-cycle strobe that writes the control bits |
| ctrlRun | input | 1 | Run bit carried by a control write |
| ctrlToggle | input | 1 | Mode bit carried by a control write (1 = toggle, 0 = pulse) |
| flagClr | input | 1 | One-cycle strobe that clears the expiry flag |
| timerOut | output | 1 | Timer output pin |
| expiryFlag | output | 1 | Sticky expiry flag |
| countValue | output | 32 | Current counter value |

## Verification
A wrong count shows up on countValue in the very next clock. It also moves the next pulse or edge on timerOut away from its reload+1 spacing, and a wrong count at the first expiry shows within one period. A wrong mode or run bit shows on timerOut at the next expiry at the latest. A frozen-state fault shows as a count that moves after a stop write. The flag is checked in the clock after each expiry and after each clear, so a dropped set or clear is caught within one clock.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // strobes from control to datapath; at most one active per clock
  typedef struct packed {
    logic restart;   // load count from reload value
    logic tickDown;  // decrement count
    logic expire;    // count at zero: reload and signal expiry
  } timerStrobes_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  timerStrobes_t strb,
  input  logic          reloadWr,
  input  logic [W-1:0]  reloadData,
  output logic          countZero,
  output logic [W-1:0]  countValue
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] reloadReg;
  logic [W-1:0] countReg;
  logic [W-1:0] reloadNext;

  // a reload written in the same clock as a load is used at once
  assign reloadNext = reloadWr ? reloadData : reloadReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= '0;
      countReg  <= '0;
    end else begin
      if (reloadWr) reloadReg <= reloadData;
      if (strb.restart || strb.expire) countReg <= reloadNext;
      else if (strb.tickDown)          countReg <= countReg - ONE;
    end
  end

  assign countZero  = (countReg == '0);
  assign countValue = countReg;

  assert_count_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.restart || strb.expire || strb.tickDown) |=> $stable(countReg));

  assert_no_tick_at_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.tickDown |-> !countZero);

  assert_reload_on_expiry_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.expire && !reloadWr) |=> (countReg == $past(reloadReg)));
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWr,
  input  logic          ctrlRun,
  input  logic          ctrlToggle,
  input  logic          flagClr,
  input  logic          countZero,
  output timerStrobes_t strb,
  output logic          timerOut,
  output logic          expiryFlag
);
  logic runReg;
  logic toggleReg;
  logic outReg;
  logic flagReg;

  always_comb begin
    strb          = '0;
    strb.restart  = ctrlWr && ctrlRun;
    strb.expire   = runReg && !ctrlWr && countZero;
    strb.tickDown = runReg && !ctrlWr && !countZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReg    <= 1'b0;
      toggleReg <= 1'b0;
      outReg    <= 1'b0;
      flagReg   <= 1'b0;
    end else begin
      if (ctrlWr) begin
        runReg    <= ctrlRun;
        toggleReg <= ctrlToggle;
      end
      if (ctrlWr || !runReg)    outReg <= 1'b0;
      else if (toggleReg)       outReg <= outReg ^ strb.expire;
      else                      outReg <= strb.expire;
      if (strb.expire)          flagReg <= 1'b1;
      else if (flagClr)         flagReg <= 1'b0;
    end
  end

  assign timerOut   = outReg;
  assign expiryFlag = flagReg;

  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.restart, strb.tickDown, strb.expire}));

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!runReg && !ctrlWr) |=> !timerOut);

  assert_flag_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.expire |=> expiryFlag);

  assert_toggle_flips_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.expire && toggleReg) |=> (timerOut != $past(timerOut)));

  assert_pulse_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.expire && !toggleReg) |=> timerOut);

  assert_write_clears_out_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> !timerOut);
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reloadWr,
  input  logic [W-1:0] reloadData,
  input  logic         ctrlWr,
  input  logic         ctrlRun,
  input  logic         ctrlToggle,
  input  logic         flagClr,
  output logic         timerOut,
  output logic         expiryFlag,
  output logic [W-1:0] countValue
);
  timerStrobes_t strb;
  logic          countZero;

  timer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWr     (ctrlWr),
    .ctrlRun    (ctrlRun),
    .ctrlToggle (ctrlToggle),
    .flagClr    (flagClr),
    .countZero  (countZero),
    .strb       (strb),
    .timerOut   (timerOut),
    .expiryFlag (expiryFlag)
  );

  timer_datapath #(.W(W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reloadWr   (reloadWr),
    .reloadData (reloadData),
    .countZero  (countZero),
    .countValue (countValue)
  );
endmodule

// File: tb/dual_mode_timer_bench.sv
module dual_mode_timer_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reloadWr;
  logic [31:0] reloadData;
  logic        ctrlWr;
  logic        ctrlRun;
  logic        ctrlToggle;
  logic        flagClr;
  logic        timerOut;
  logic        expiryFlag;
  logic [31:0] countValue;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_mode_timer u_dual_mode_timer (
    .clk(clk), .rstN(rstN), .reloadWr(reloadWr), .reloadData(reloadData),
    .ctrlWr(ctrlWr), .ctrlRun(ctrlRun), .ctrlToggle(ctrlToggle),
    .flagClr(flagClr), .timerOut(timerOut), .expiryFlag(expiryFlag),
    .countValue(countValue)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; reloadWr = 0; reloadData = 0; ctrlWr = 0;
    ctrlRun = 0; ctrlToggle = 0; flagClr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeReload(input logic [31:0] v);
    reloadWr = 1; reloadData = v;
    @(negedge clk);
    reloadWr = 0;
  endtask

  // returns at the first negedge after the write edge (N1)
  task automatic writeCtrl(input logic run, input logic tog);
    ctrlWr = 1; ctrlRun = run; ctrlToggle = tog;
    @(negedge clk);
    ctrlWr = 0;
  endtask

  task automatic testReset();
    doReset();
    check(timerOut == 0, "R1 out", timerOut, 0);
    check(expiryFlag == 0, "R1 flag", expiryFlag, 0);
    check(countValue == 0, "R1 count", countValue, 0);
    repeat (3) @(negedge clk);
    check(countValue == 0 && timerOut == 0, "R1 stopped", countValue, 0);
  endtask

  task automatic testPulse(input int r);
    doReset();
    writeReload(r);
    writeCtrl(1, 0);
    for (int n = 1; n <= 4 * (r + 1) + 2; n++) begin
      automatic logic expOut = (n >= r + 2) && (((n - 1) % (r + 1)) == 0);
      automatic int expCnt = (r - ((n - 1) % (r + 1)));
      check(countValue == expCnt, "R2 count", countValue, expCnt);
      check(timerOut == expOut, "R3 pulse", timerOut, expOut);
      check(expiryFlag == (n >= r + 2), "R7 flag set", expiryFlag, n >= r + 2);
      @(negedge clk);
    end
  endtask

  task automatic testToggle(input int r);
    doReset();
    writeReload(r);
    writeCtrl(1, 1);
    for (int n = 1; n <= 4 * (r + 1) + 2; n++) begin
      automatic logic expOut = ((n - 1) / (r + 1)) % 2;
      check(timerOut == expOut, "R4 toggle", timerOut, expOut);
      @(negedge clk);
    end
  endtask

  task automatic testZeroReload();
    doReset();
    writeReload(0);
    writeCtrl(1, 0);
    @(negedge clk);
    for (int n = 0; n < 6; n++) begin
      check(timerOut == 1 && countValue == 0, "R5 pulse zero", timerOut, 1);
      @(negedge clk);
    end
    writeCtrl(1, 1);
    for (int n = 1; n <= 6; n++) begin
      check(timerOut == ((n - 1) % 2), "R5 toggle zero", timerOut, (n - 1) % 2);
      @(negedge clk);
    end
  endtask

  task automatic testStop();
    doReset();
    writeReload(4);
    writeCtrl(1, 1);
    @(negedge clk);
    @(negedge clk);             // N3: count 2
    check(countValue == 2, "R6 pre-stop count", countValue, 2);
    writeCtrl(0, 1);
    for (int n = 0; n < 10; n++) begin
      check(countValue == 2, "R6 frozen count", countValue, 2);
      check(timerOut == 0, "R6 out low", timerOut, 0);
      check(expiryFlag == 0, "R6 no expiry", expiryFlag, 0);
      @(negedge clk);
    end
  endtask

  task automatic testFlagClear();
    doReset();
    writeReload(3);
    writeCtrl(1, 0);
    repeat (4) @(negedge clk);  // N5
    check(expiryFlag == 1, "R7 flag after expiry", expiryFlag, 1);
    @(negedge clk);             // N6
    flagClr = 1;
    @(negedge clk);             // N7
    flagClr = 0;
    check(expiryFlag == 0, "R7 flag cleared", expiryFlag, 0);
    @(negedge clk);             // N8
    check(expiryFlag == 0, "R7 flag stays clear", expiryFlag, 0);
    @(negedge clk);             // N9
    check(expiryFlag == 1, "R7 flag sets again", expiryFlag, 1);
    doReset();
    writeReload(0);
    writeCtrl(1, 0);
    flagClr = 1;
    repeat (3) @(negedge clk);
    check(expiryFlag == 1, "R7 set wins over clear", expiryFlag, 1);
    flagClr = 0;
  endtask

  task automatic testRestart();
    doReset();
    writeReload(2);
    writeCtrl(1, 1);
    repeat (4) @(negedge clk);  // N5
    check(timerOut == 1, "R8 toggled high", timerOut, 1);
    writeCtrl(1, 1);
    check(timerOut == 0, "R8 out cleared", timerOut, 0);
    check(countValue == 2, "R8 count reloaded", countValue, 2);
  endtask

  task automatic testReloadChange();
    doReset();
    writeReload(5);
    writeCtrl(1, 0);
    reloadWr = 1; reloadData = 2;   // N1 write, edge E1
    @(negedge clk);                 // N2
    reloadWr = 0;
    check(countValue == 4, "R9 count untouched", countValue, 4);
    repeat (5) @(negedge clk);      // N7: first expiry seen
    check(countValue == 2 && timerOut == 1, "R9 new reload at expiry", countValue, 2);
    repeat (3) @(negedge clk);      // N10
    check(timerOut == 1 && countValue == 2, "R9 new period", timerOut, 1);
  endtask

  initial begin
    fork
      begin
        testReset();
        testPulse(3);
        testPulse(1);
        testToggle(2);
        testToggle(4);
        testZeroReload();
        testStop();
        testFlagClear();
        testRestart();
        testReloadChange();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule